// File: doc/BRIEF.md
# External Bus Read Timing Sequencer

This block turns a simple internal read request into a timed read cycle on an external parallel memory bus. Each cycle runs through a setup phase (called lead), a strobe phase (called active) and a hold phase (called trail). The length of each phase, in timing-clock cycles, comes from configuration inputs. A synchronous ready input can stretch the strobe phase when a slow device needs more time. Read data is captured when the strobe ends. The requester then receives a one-cycle acknowledge, with the data, after the hold phase.

The block also produces the external bus clock, which runs at the timing-clock rate or at half that rate. In half-rate mode every access must begin on a rising edge of that clock, so a single dead cycle is inserted when a request lands on the wrong phase. While no access is running, the address bus keeps the last address it drove, with bit 0 forced high. The bus can be configured for 16 or 32 data bits. In 16-bit mode the upper write-enable pin carries address bit 0.

Top module: `ebus_rd_seq`

## Requirements
- R1: After reset, chip select, read strobe and both write enables are high, the acknowledge is low and address bit 0 is high.
- R2: An accepted read holds chip select low for exactly lead + active + trail timing-clock cycles. The read strobe is low for the active cycles only, starting after the lead cycles. A length field of 0 counts as 1.
- R3: With half-rate mode set, the bus clock toggles every timing-clock cycle and is high in the first lead cycle. When a request is accepted while the bus clock is high, one alignment cycle with chip select high comes first, so chip select falls two cycles after the request is raised instead of one.
- R4: During an access the address bus carries the requested address unchanged. Outside accesses, including alignment cycles, it keeps the last address driven with bit 0 forced high.
- R5: The first write enable and the read/write line (1 = read) stay high. The second write enable stays high in 32-bit mode. In 16-bit mode it carries address bit 0.
- R6: With ready usage on, ready is first sampled at the end of lead + active cycles. Each low sample adds one active cycle, and the strobe phase ends at the first high sample.
- R7: With ready usage off, the active phase lasts exactly its programmed length whatever the ready input does.
- R8: Read data is captured on the clock edge that ends the strobe phase. In 16-bit mode only the low 16 data bits are kept and the upper bits return as zero. The acknowledge is a one-cycle pulse in the cycle after trail ends, with the captured data alongside.
- R9: The lead, active and trail lengths, the ready usage bit and the width bit are taken when a request is accepted. Changing them later leaves the running access unchanged.
- R10: A request is accepted only while the sequencer is idle and not presenting an acknowledge. The requester holds the valid line until it sees the acknowledge, and accesses can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lead | input | LEAD_W | Lead phase length (0 treated as 1) |
| cfg_active | input | ACT_W | Active phase length (0 treated as 1) |
| cfg_trail | input | TRL_W | Trail phase length (0 treated as 1) |
| cfg_use_rdy | input | 1 | Stretch the active phase with the ready input |
| cfg_wide | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| cfg_half_clk | input | 1 | 1 = bus clock at half the timing-clock rate |
| req_valid | input | 1 | Read request, held until acknowledged |
| req_addr | input | AW | Read address |
| req_ack | output | 1 | One-cycle completion pulse |
| req_data | output | DW | Read data, valid with req_ack |
| bus_clk_o | output | 1 | External bus clock |
| bus_cs_n | output | 1 | Zone chip select, active low |
| bus_addr | output | AW | External address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_rnw | output | 1 | Read/write line, high for read |
| bus_we0_n | output | 1 | Low write enable, inactive |
| bus_we1_n | output | 1 | High write enable, or address bit 0 in 16-bit mode |
| bus_din | input | DW | External read data |
| bus_rdy | input | 1 | Synchronous ready |

## Verification
The bench builds the block with its defaults: a 20-bit address, a 32-bit data bus, and lead, active and trail fields of 2, 3 and 2 bits. These widths allow the largest lengths (3, 7, 3) to be reached alongside the zero-as-one case within a few cycles per access. The 32-bit bus lets the same build cover both the zero-extended 16-bit capture and the full-width capture. A ready model stalls a chosen number of samples after the programmed active length. Repeated half-rate requests at varying gaps land on both bus-clock phases, which covers both the aligned path and the path with an alignment cycle.

// File: rtl/ebus_rd_pkg.sv
package ebus_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_LEAD,
        ST_ACT,
        ST_TRAIL
    } seq_st_e;

endpackage

// File: rtl/ebus_busclk.sv
module ebus_busclk (
    input  logic clk,
    input  logic rst_n,
    input  logic half_en,
    output logic phase_hi,
    output logic align_ok,
    output logic clk_out
);

    typedef struct packed {
        logic div;
    } clk_state_t;

    clk_state_t clk_d, clk_q;

    always_comb begin
        clk_d = clk_q;
        if (half_en) begin
            clk_d.div = ~clk_q.div;
        end else begin
            clk_d.div = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q <= '0;
        end else begin
            clk_q <= clk_d;
        end
    end

    assign phase_hi = clk_q.div;
    // A lead phase may start at the next edge only if the divided clock rises there.
    assign align_ok = ~half_en | ~clk_q.div;
    assign clk_out  = half_en ? clk_q.div : clk;

    AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(half_en) && half_en |-> clk_q.div != $past(clk_q.div)); // R3

endmodule

// File: rtl/ebus_rd_core.sv
module ebus_rd_core
    import ebus_rd_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 32,
    parameter int LEAD_W = 2,
    parameter int ACT_W  = 3,
    parameter int TRL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAD_W-1:0] cfg_lead,
    input  logic [ACT_W-1:0]  cfg_active,
    input  logic [TRL_W-1:0]  cfg_trail,
    input  logic              cfg_use_rdy,
    input  logic              cfg_wide,
    input  logic              align_ok,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic              req_ack,
    output logic [DW-1:0]     req_data,
    output logic              bus_cs_n,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rd_n,
    output logic              wide_mode,
    input  logic [DW-1:0]     bus_din,
    input  logic              bus_rdy
);

    localparam int LA_W  = (LEAD_W > ACT_W) ? LEAD_W : ACT_W;
    localparam int CNT_W = (LA_W > TRL_W) ? LA_W : TRL_W;
    localparam int HW    = DW / 2;

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] trl;
        logic             use_rdy;
        logic             wide;
        logic [AW-1:0]    pend;
        logic [AW-1:0]    addr;
        logic             cs_n;
        logic             rd_n;
        logic             ack;
        logic [DW-1:0]    data;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    always_comb begin
        seq_d     = seq_q;
        seq_d.ack = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid && !seq_q.ack) begin
                    seq_d.lead    = at_least_one(CNT_W'(cfg_lead));
                    seq_d.act     = at_least_one(CNT_W'(cfg_active));
                    seq_d.trl     = at_least_one(CNT_W'(cfg_trail));
                    seq_d.use_rdy = cfg_use_rdy;
                    seq_d.wide    = cfg_wide;
                    seq_d.pend    = req_addr;
                    if (align_ok) begin
                        seq_d.st   = ST_LEAD;
                        seq_d.cnt  = at_least_one(CNT_W'(cfg_lead)) - CNT_W'(1);
                        seq_d.addr = req_addr;
                        seq_d.cs_n = 1'b0;
                    end else begin
                        seq_d.st = ST_ALIGN;
                    end
                end
            end
            ST_ALIGN: begin
                seq_d.st   = ST_LEAD;
                seq_d.cnt  = seq_q.lead - CNT_W'(1);
                seq_d.addr = seq_q.pend;
                seq_d.cs_n = 1'b0;
            end
            ST_LEAD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st   = ST_ACT;
                    seq_d.cnt  = seq_q.act - CNT_W'(1);
                    seq_d.rd_n = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_ACT: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end else if (!seq_q.use_rdy || bus_rdy) begin
                    seq_d.st   = ST_TRAIL;
                    seq_d.cnt  = seq_q.trl - CNT_W'(1);
                    seq_d.rd_n = 1'b1;
                    seq_d.data = seq_q.wide ? bus_din : DW'(bus_din[HW-1:0]);
                end
            end
            ST_TRAIL: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st      = ST_IDLE;
                    seq_d.cs_n    = 1'b1;
                    seq_d.addr[0] = 1'b1;
                    seq_d.ack     = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                seq_d.st   = ST_IDLE;
                seq_d.cs_n = 1'b1;
                seq_d.rd_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, lead: CNT_W'(1), act: CNT_W'(1),
                       trl: CNT_W'(1), use_rdy: 1'b0, wide: 1'b0, pend: '0,
                       addr: AW'(1), cs_n: 1'b1, rd_n: 1'b1, ack: 1'b0, data: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ack   = seq_q.ack;
    assign req_data  = seq_q.data;
    assign bus_cs_n  = seq_q.cs_n;
    assign bus_addr  = seq_q.addr;
    assign bus_rd_n  = seq_q.rd_n;
    assign wide_mode = seq_q.wide;

    AST_NO_RDY_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == ST_ACT && seq_q.cnt == '0 && !seq_q.use_rdy |=> bus_rd_n); // R7
    AST_RDY_LOW_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n && seq_q.cnt == '0 && seq_q.use_rdy && !bus_rdy |=> !bus_rd_n); // R6
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack && !seq_q.wide |-> req_data[DW-1:HW] == '0); // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n && $past(!bus_cs_n) |-> $stable(seq_q.act) && $stable(seq_q.trl)); // R9

endmodule

// File: rtl/ebus_rd_seq.sv
module ebus_rd_seq #(
    parameter int AW     = 20,
    parameter int DW     = 32,
    parameter int LEAD_W = 2,
    parameter int ACT_W  = 3,
    parameter int TRL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAD_W-1:0] cfg_lead,
    input  logic [ACT_W-1:0]  cfg_active,
    input  logic [TRL_W-1:0]  cfg_trail,
    input  logic              cfg_use_rdy,
    input  logic              cfg_wide,
    input  logic              cfg_half_clk,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    output logic              req_ack,
    output logic [DW-1:0]     req_data,
    output logic              bus_clk_o,
    output logic              bus_cs_n,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rd_n,
    output logic              bus_rnw,
    output logic              bus_we0_n,
    output logic              bus_we1_n,
    input  logic [DW-1:0]     bus_din,
    input  logic              bus_rdy
);

    logic phase_hi;
    logic align_ok;
    logic wide_mode;

    ebus_busclk u_busclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_en  (cfg_half_clk),
        .phase_hi (phase_hi),
        .align_ok (align_ok),
        .clk_out  (bus_clk_o)
    );

    ebus_rd_core #(
        .AW     (AW),
        .DW     (DW),
        .LEAD_W (LEAD_W),
        .ACT_W  (ACT_W),
        .TRL_W  (TRL_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_lead    (cfg_lead),
        .cfg_active  (cfg_active),
        .cfg_trail   (cfg_trail),
        .cfg_use_rdy (cfg_use_rdy),
        .cfg_wide    (cfg_wide),
        .align_ok    (align_ok),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_ack     (req_ack),
        .req_data    (req_data),
        .bus_cs_n    (bus_cs_n),
        .bus_addr    (bus_addr),
        .bus_rd_n    (bus_rd_n),
        .wide_mode   (wide_mode),
        .bus_din     (bus_din),
        .bus_rdy     (bus_rdy)
    );

    // Read-only sequencer: direction line and low write enable stay inactive.
    assign bus_rnw   = 1'b1;
    assign bus_we0_n = 1'b1;
    assign bus_we1_n = wide_mode ? 1'b1 : bus_addr[0];

    AST_RD_WITHIN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_cs_n); // R2
    AST_IDLE_A0_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> bus_addr[0]); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n && $past(!bus_cs_n) |-> $stable(bus_addr)); // R4
    AST_LEAD_ON_BUS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) && cfg_half_clk && $past(cfg_half_clk) |-> phase_hi); // R3
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R8
    AST_ACK_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ack) |-> $rose(bus_cs_n)); // R8

endmodule

// File: tb/tb_ebus_rd_seq.sv
`timescale 1ns/1ps
module tb_ebus_rd_seq;

    localparam int AW = 20;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_lead = '0;
    logic [2:0]    cfg_active = '0;
    logic [1:0]    cfg_trail = '0;
    logic          cfg_use_rdy = 1'b0;
    logic          cfg_wide = 1'b1;
    logic          cfg_half_clk = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ack;
    logic [DW-1:0] req_data;
    logic          bus_clk_o, bus_cs_n, bus_rd_n, bus_rnw, bus_we0_n, bus_we1_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_din;
    logic          bus_rdy = 1'b0;

    always #2.5 clk = ~clk;

    ebus_rd_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
        .cfg_trail(cfg_trail), .cfg_use_rdy(cfg_use_rdy), .cfg_wide(cfg_wide),
        .cfg_half_clk(cfg_half_clk), .req_valid(req_valid), .req_addr(req_addr),
        .req_ack(req_ack), .req_data(req_data), .bus_clk_o(bus_clk_o),
        .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_rnw(bus_rnw), .bus_we0_n(bus_we0_n), .bus_we1_n(bus_we1_n),
        .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5AA5, a[15:0] + 16'h1357};
    endfunction

    // External device model: drives data only while the strobe is low.
    assign bus_din = !bus_rd_n ? mem_word(bus_addr) : 32'hDEAD_BEEF;

    typedef struct {
        logic [AW-1:0] addr;
        logic [31:0]   data;
        int            lead;
        int            act;
        int            trl;
        int            stall;
        bit            use_rdy;
        bit            wide;
        bit            half;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Monitor: counts phases of each access and compares at the acknowledge.
    int mon_lead = 0, mon_act = 0, mon_trl = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!bus_cs_n && exp_q.size() > 0) begin
                if (!bus_rd_n) begin
                    mon_act++;
                    if (mon_act == 1)
                        chk(bus_addr == exp_q[0].addr, "R4", "addr in active",
                            32'(bus_addr), 32'(exp_q[0].addr));
                end else if (mon_act == 0) begin
                    mon_lead++;
                    if (mon_lead == 1) begin
                        chk(bus_addr == exp_q[0].addr, "R4", "addr in lead",
                            32'(bus_addr), 32'(exp_q[0].addr));
                        chk(bus_we1_n == (exp_q[0].wide ? 1'b1 : exp_q[0].addr[0]), "R5",
                            "we1_n", 32'(bus_we1_n), 32'(exp_q[0].wide ? 1'b1 : exp_q[0].addr[0]));
                        chk(bus_we0_n && bus_rnw, "R5", "we0_n/rnw",
                            {30'd0, bus_we0_n, bus_rnw}, 32'd3);
                        if (exp_q[0].half)
                            chk(bus_clk_o == 1'b1, "R3", "bus clock in first lead",
                                32'(bus_clk_o), 32'd1);
                    end
                end else begin
                    mon_trl++;
                end
            end
            if (exp_q.size() > 0 && exp_q[0].use_rdy)
                bus_rdy = (mon_act >= exp_q[0].act + exp_q[0].stall);
            else
                bus_rdy = 1'b0;
            if (req_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected ack", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(mon_lead == e.lead, "R2", "lead cycles", 32'(mon_lead), 32'(e.lead));
                    chk(mon_act == e.act + e.stall, e.use_rdy ? "R6" : "R7", "active cycles",
                        32'(mon_act), 32'(e.act + e.stall));
                    chk(mon_trl == e.trl, "R2", "trail cycles", 32'(mon_trl), 32'(e.trl));
                    chk(req_data == e.data, e.wide ? "R8" : "R8 narrow", "data",
                        req_data, e.data);
                    chk(bus_cs_n && bus_rd_n, "R2", "strobes idle at ack",
                        {30'd0, bus_cs_n, bus_rd_n}, 32'd3);
                    chk(bus_addr == {e.addr[AW-1:1], 1'b1}, "R4", "idle addr",
                        32'(bus_addr), 32'({e.addr[AW-1:1], 1'b1}));
                end
                mon_lead = 0;
                mon_act  = 0;
                mon_trl  = 0;
            end
        end
    end

    // Driver: programs the configuration, raises the request, pushes the expectation.
    task automatic run_read(input logic [AW-1:0] a, input int lf, input int af, input int tf,
                            input bit use_r, input int stall, input bit wide, input bit chg);
        exp_t e;
        int   dly;
        bit   align;
        @(negedge clk);
        cfg_lead    = 2'(lf);
        cfg_active  = 3'(af);
        cfg_trail   = 2'(tf);
        cfg_use_rdy = use_r;
        cfg_wide    = wide;
        req_addr    = a;
        e.addr    = a;
        e.lead    = (lf == 0) ? 1 : lf;
        e.act     = (af == 0) ? 1 : af;
        e.trl     = (tf == 0) ? 1 : tf;
        e.use_rdy = use_r;
        e.stall   = use_r ? stall : 0;
        e.wide    = wide;
        e.half    = cfg_half_clk;
        e.data    = wide ? mem_word(a) : {16'd0, mem_word(a)[15:0]};
        align     = cfg_half_clk && bus_clk_o;
        exp_q.push_back(e);
        req_valid = 1'b1;
        dly = 0;
        do begin
            @(negedge clk);
            dly++;
            if (chg && dly == 1) begin
                // R9: scramble configuration after acceptance
                cfg_lead    = 2'd3;
                cfg_active  = 3'd6;
                cfg_trail   = 2'd3;
                cfg_use_rdy = ~use_r;
                cfg_wide    = ~wide;
            end
        end while (bus_cs_n);
        chk(dly == (align ? 2 : 1), "R3", "request to chip select delay",
            32'(dly), align ? 32'd2 : 32'd1);
        while (!req_ack) @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_cs_n && bus_rd_n && bus_we0_n && bus_we1_n, "R1", "strobes in reset",
            {28'd0, bus_cs_n, bus_rd_n, bus_we0_n, bus_we1_n}, 32'hF);
        chk(!req_ack && bus_addr[0], "R1", "ack low, a0 high", {30'd0, req_ack, bus_addr[0]}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && bus_addr[0], "R1", "idle after reset", {30'd0, bus_cs_n, bus_addr[0]}, 32'd3);

        // R2 basic lengths, full-rate, wide
        run_read(20'h12344, 1, 1, 1, 1'b0, 0, 1'b1, 1'b0);
        run_read(20'hABCDE, 3, 7, 3, 1'b0, 0, 1'b1, 1'b0);
        // R2 zero fields count as one
        run_read(20'h00F00, 0, 0, 0, 1'b0, 0, 1'b1, 1'b0);
        // R5 R8 narrow mode, odd and even address
        run_read(20'h55551, 2, 3, 1, 1'b0, 0, 1'b0, 1'b0);
        run_read(20'h2AAA2, 1, 2, 2, 1'b0, 0, 1'b0, 1'b0);
        // R6 ready stretch: none and three stalls
        run_read(20'h31337, 1, 3, 1, 1'b1, 0, 1'b1, 1'b0);
        run_read(20'h0BEEF, 2, 2, 2, 1'b1, 3, 1'b1, 1'b0);
        run_read(20'hFFFFF, 1, 1, 1, 1'b1, 5, 1'b0, 1'b0);
        // R7 ready usage off with ready held low
        run_read(20'h7A7A7, 1, 4, 1, 1'b0, 4, 1'b1, 1'b0);
        // R9 configuration changed mid-access
        run_read(20'h13579, 1, 2, 1, 1'b1, 2, 1'b1, 1'b1);
        run_read(20'h24680, 2, 1, 1, 1'b0, 0, 1'b0, 1'b1);

        // R3 half-rate bus clock, requests on both phases
        @(negedge clk);
        cfg_half_clk = 1'b1;
        @(negedge clk);
        begin
            logic prev;
            prev = bus_clk_o;
            @(negedge clk);
            chk(bus_clk_o != prev, "R3", "bus clock toggles", 32'(bus_clk_o), 32'(~prev));
        end
        for (int g = 0; g < 4; g++) begin
            repeat (g) @(negedge clk);
            run_read(20'h40000 + 20'(g * 3), 1 + (g % 3), 2, 1 + (g % 2), g[0], g, g[1], 1'b0);
        end
        cfg_half_clk = 1'b0;

        // R10 back-to-back requests at full rate
        run_read(20'h11111, 1, 1, 1, 1'b0, 0, 1'b1, 1'b0);
        run_read(20'h22222, 1, 1, 1, 1'b0, 0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "all requests acknowledged", 32'(exp_q.size()), 32'd0);
        chk(!req_ack && bus_cs_n, "R10", "no extra access", {30'd0, req_ack, bus_cs_n}, 32'd1);
        done = 1'b1;
        report();
    end

endmodule